// File: doc/BRIEF.md
# Instruction Encoding Match Checker

This block looks at a fixed-size instruction buffer of up to 15 bytes, byte 0 first, and decides for each of a small set of generalized instruction shapes whether the buffer holds a clean encoding of that shape. A shape is described by a few fixed bits that must equal constants, such as the opcode and the ModRM mode bits. It also has an encoding length, and every byte past that length must be zero. The bits that name the operand register take no part in the decision. Each shape is decoded from byte 0 of the buffer.

The checker is purely combinational. It raises one flag per shape and a single flag that is set only when exactly one shape matched. It also returns the 3-bit register number and the immediate value taken from the winning encoding. A surrounding verifier uses the single flag as its "only one instruction executed" condition, and uses the register number to steer its operand selection.

Top module: `insn_encoding_checker`

## Requirements
- R1: Flag bit 0 (no-op shape) is set exactly when byte 0 equals 0x90 and bytes 1 to 14 are all zero. An all-zero buffer sets no flag.
- R2: Flag bit 1 (move 32-bit immediate into register) is set exactly when byte0[7:3] equals 5'b10111 (bytes 0xB8 to 0xBF) and bytes 5 to 14 are zero. When it is the only hit, reg_sel is byte0[2:0] and imm_val is bytes 1 to 4 taken little-endian.
- R3: Flag bit 2 (register increment) is set exactly when byte 0 is 0xFF, byte1[7:3] equals 5'b11000, and bytes 2 to 14 are zero. When it is the only hit, reg_sel is byte1[2:0] and imm_val is 0.
- R4: Flag bit 3 (register push) is set exactly when byte0[7:3] equals 5'b01010 (bytes 0x50 to 0x57) and bytes 1 to 14 are zero. When it is the only hit, reg_sel is byte0[2:0] and imm_val is 0.
- R5: Flag bit 4 (add 8-bit immediate to register) is set exactly when byte 0 is 0x83, byte1[7:3] equals 5'b11000, and bytes 3 to 14 are zero. When it is the only hit, reg_sel is byte1[2:0] and imm_val is byte 2 sign-extended to 32 bits.
- R6: The register-selecting bits (byte0[2:0] for bits 1 and 3, byte1[2:0] for bits 2 and 4) have no effect on any match flag. All eight values give the same flags.
- R7: A nonzero value in any byte past a shape's encoding length clears that shape's flag, at every position up to byte 14.
- R8: one_hit is 1 exactly when one flag is set. When one_hit is 0, reg_sel and imm_val are both 0. All outputs follow the buffer in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_bits | input | 120 | Instruction buffer; byte k occupies bits [8k+7:8k] |
| ctx_hit | output | 5 | One match flag per shape, bit order as in R1 to R5 |
| one_hit | output | 1 | Exactly one shape matched |
| reg_sel | output | 3 | Register number from the single matching encoding, else 0 |
| imm_val | output | 32 | Immediate from the single matching encoding, else 0 |

## Verification
The bench sweeps every value of byte 0, and every value of byte 1 behind the two ModRM shapes. This catches a mask that is one bit too wide or too narrow, which would accept neighbouring opcodes such as 0xB7 or 0xC0, or a ModRM mode other than register-direct. A walk of three nonzero values through each of the 15 byte positions, behind every shape, targets an off-by-one encoding length: a wrong length would either reject a valid immediate byte or let a dirty trailing byte pass. The bench also walks all eight register numbers and mixes pseudo-random immediates. These patterns expose register bits leaking into the compare, byte-swapped immediates, and a missing sign extension on the 8-bit add immediate.

// File: rtl/imc_pkg.sv
package imc_pkg;

  localparam int MAX_INSN_BYTES = 15;
  localparam int BYTE_W         = 8;
  localparam int REG_W          = 3;
  localparam int IMM_W          = 32;
  localparam int NUM_CTX        = 5;
  localparam int HEAD_BYTES     = 5;   // longest shape encoding

  localparam int CTX_NOP  = 0;
  localparam int CTX_MOVI = 1;
  localparam int CTX_INC  = 2;
  localparam int CTX_PUSH = 3;
  localparam int CTX_ADDI = 4;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_B0   = 2'd1,
    REG_B1   = 2'd2
  } reg_src_e;

  typedef struct packed {
    logic [7:0] pat0;
    logic [7:0] msk0;
    logic       chk_b1;
    logic [7:0] pat1;
    logic [7:0] msk1;
    logic [3:0] enc_len;
    reg_src_e   reg_src;
    logic [3:0] imm_off;
    logic [2:0] imm_len;
    logic       imm_sext;
  } ctx_desc_t;

  // Shape table: fixed-bit patterns, masks (register bits cleared), lengths.
  function automatic ctx_desc_t ctx_desc(input int idx);
    ctx_desc_t d;
    d = '0;
    case (idx)
      CTX_NOP: begin
        d.pat0 = 8'h90; d.msk0 = 8'hFF; d.enc_len = 4'd1;
      end
      CTX_MOVI: begin
        d.pat0 = 8'hB8; d.msk0 = 8'hF8; d.enc_len = 4'd5;
        d.reg_src = REG_B0; d.imm_off = 4'd1; d.imm_len = 3'd4;
      end
      CTX_INC: begin
        d.pat0 = 8'hFF; d.msk0 = 8'hFF; d.chk_b1 = 1'b1;
        d.pat1 = 8'hC0; d.msk1 = 8'hF8; d.enc_len = 4'd2;
        d.reg_src = REG_B1;
      end
      CTX_PUSH: begin
        d.pat0 = 8'h50; d.msk0 = 8'hF8; d.enc_len = 4'd1;
        d.reg_src = REG_B0;
      end
      CTX_ADDI: begin
        d.pat0 = 8'h83; d.msk0 = 8'hFF; d.chk_b1 = 1'b1;
        d.pat1 = 8'hC0; d.msk1 = 8'hF8; d.enc_len = 4'd3;
        d.reg_src = REG_B1; d.imm_off = 4'd2; d.imm_len = 3'd1; d.imm_sext = 1'b1;
      end
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/imc_tail_scan.sv
module imc_tail_scan #(
  parameter int BUF_BYTES = imc_pkg::MAX_INSN_BYTES,
  parameter int NUM_CTX   = imc_pkg::NUM_CTX
) (
  input  logic [8*BUF_BYTES-1:0] insn,
  output logic [NUM_CTX-1:0]     tail_ok,
  output logic                   buf_empty
);

  // zero_from[k]: bytes k .. BUF_BYTES-1 are all zero.
  logic [BUF_BYTES:0] zero_from;

  assign zero_from[BUF_BYTES] = 1'b1;

  for (genvar k = 0; k < BUF_BYTES; k++) begin : g_chain
    assign zero_from[k] = (insn[8*k +: 8] == 8'h00) && zero_from[k+1];
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    localparam imc_pkg::ctx_desc_t D   = imc_pkg::ctx_desc(c);
    localparam int                 LEN = int'(D.enc_len);
    if (LEN <= BUF_BYTES) begin : g_fit
      assign tail_ok[c] = zero_from[LEN];
    end else begin : g_nofit
      assign tail_ok[c] = 1'b0;
    end
  end

  assign buf_empty = zero_from[0];

endmodule

// File: rtl/imc_ctx_match.sv
module imc_ctx_match #(
  parameter imc_pkg::ctx_desc_t DESC = '0,
  parameter int HEAD_BYTES = imc_pkg::HEAD_BYTES,
  parameter int REG_W      = imc_pkg::REG_W,
  parameter int IMM_W      = imc_pkg::IMM_W
) (
  input  logic [8*HEAD_BYTES-1:0] head,
  input  logic                    tail_ok,
  output logic                    hit,
  output logic [REG_W-1:0]        reg_field,
  output logic [IMM_W-1:0]        imm_field
);

  localparam int HEAD_W = 8*HEAD_BYTES;

  // Field pick: upper index exclusive, lower index inclusive.
  function automatic logic [IMM_W-1:0] pick(input logic [HEAD_W-1:0] h,
                                            input int hi_x, input int lo_i);
    logic [IMM_W-1:0] r;
    r = '0;
    for (int i = 0; i < IMM_W; i++) begin
      if ((lo_i + i < hi_x) && (lo_i + i < HEAD_W)) r[i] = h[lo_i + i];
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pick_reg(input logic [HEAD_W-1:0] h,
                                                input int lo_i);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (lo_i + i < HEAD_W) r[i] = h[lo_i + i];
    end
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] widen(input logic [IMM_W-1:0] raw,
                                             input int nbits, input logic sext);
    logic [IMM_W-1:0] r;
    r = raw;
    if (sext && nbits > 0 && nbits < IMM_W) begin
      for (int i = 0; i < IMM_W; i++) begin
        if (i >= nbits) r[i] = raw[nbits-1];
      end
    end
    return r;
  endfunction

  localparam int IMM_LO = 8*int'(DESC.imm_off);
  localparam int IMM_NB = 8*int'(DESC.imm_len);

  logic [7:0] byte0;
  logic [7:0] byte1;
  logic       fixed_ok;
  logic       unused_head;

  assign byte0       = head[7:0];
  assign byte1       = head[15:8];
  assign unused_head = ^head;

  always_comb begin
    fixed_ok = ((byte0 & DESC.msk0) == DESC.pat0);
    if (DESC.chk_b1) fixed_ok = fixed_ok && ((byte1 & DESC.msk1) == DESC.pat1);
  end

  assign hit = fixed_ok && tail_ok;

  always_comb begin
    case (DESC.reg_src)
      imc_pkg::REG_B0: reg_field = pick_reg(head, 0);
      imc_pkg::REG_B1: reg_field = pick_reg(head, 8);
      default:         reg_field = '0;
    endcase
  end

  always_comb begin
    if (IMM_NB == 0) imm_field = '0;
    else imm_field = widen(pick(head, IMM_LO + IMM_NB, IMM_LO), IMM_NB, DESC.imm_sext);
  end

endmodule

// File: rtl/imc_one_judge.sv
module imc_one_judge #(
  parameter int NUM_CTX = imc_pkg::NUM_CTX,
  parameter int REG_W   = imc_pkg::REG_W,
  parameter int IMM_W   = imc_pkg::IMM_W
) (
  input  logic [NUM_CTX-1:0]            hit,
  input  logic [NUM_CTX-1:0][REG_W-1:0] reg_fields,
  input  logic [NUM_CTX-1:0][IMM_W-1:0] imm_fields,
  output logic                          one_hit,
  output logic [REG_W-1:0]              reg_sel,
  output logic [IMM_W-1:0]              imm_val
);

  localparam int CNT_W = $clog2(NUM_CTX + 1);

  logic [CNT_W-1:0] n_hits;
  logic [REG_W-1:0] reg_or;
  logic [IMM_W-1:0] imm_or;

  always_comb begin
    n_hits = '0;
    reg_or = '0;
    imm_or = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (hit[c]) begin
        n_hits = n_hits + CNT_W'(1);
        reg_or = reg_or | reg_fields[c];
        imm_or = imm_or | imm_fields[c];
      end
    end
  end

  assign one_hit = (n_hits == CNT_W'(1));
  assign reg_sel = one_hit ? reg_or : '0;
  assign imm_val = one_hit ? imm_or : '0;

endmodule

// File: rtl/insn_encoding_checker.sv
module insn_encoding_checker #(
  parameter int BUF_BYTES = imc_pkg::MAX_INSN_BYTES,
  parameter int NUM_CTX   = imc_pkg::NUM_CTX,
  parameter int REG_W     = imc_pkg::REG_W,
  parameter int IMM_W     = imc_pkg::IMM_W
) (
  input  logic [8*BUF_BYTES-1:0] instr_bits,
  output logic [NUM_CTX-1:0]     ctx_hit,
  output logic                   one_hit,
  output logic [REG_W-1:0]       reg_sel,
  output logic [IMM_W-1:0]       imm_val
);

  localparam int BUF_W      = 8*BUF_BYTES;
  localparam int HEAD_BYTES = imc_pkg::HEAD_BYTES;
  localparam int HEAD_W     = 8*HEAD_BYTES;

  logic [NUM_CTX-1:0]            tail_ok;
  logic                          buf_empty;
  logic [NUM_CTX-1:0][REG_W-1:0] reg_fields;
  logic [NUM_CTX-1:0][IMM_W-1:0] imm_fields;

  imc_tail_scan #(
    .BUF_BYTES (BUF_BYTES),
    .NUM_CTX   (NUM_CTX)
  ) tail_i (
    .insn      (instr_bits),
    .tail_ok   (tail_ok),
    .buf_empty (buf_empty)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    imc_ctx_match #(
      .DESC       (imc_pkg::ctx_desc(c)),
      .HEAD_BYTES (HEAD_BYTES),
      .REG_W      (REG_W),
      .IMM_W      (IMM_W)
    ) match_i (
      .head      (instr_bits[HEAD_W-1:0]),
      .tail_ok   (tail_ok[c]),
      .hit       (ctx_hit[c]),
      .reg_field (reg_fields[c]),
      .imm_field (imm_fields[c])
    );
  end

  imc_one_judge #(
    .NUM_CTX (NUM_CTX),
    .REG_W   (REG_W),
    .IMM_W   (IMM_W)
  ) judge_i (
    .hit        (ctx_hit),
    .reg_fields (reg_fields),
    .imm_fields (imm_fields),
    .one_hit    (one_hit),
    .reg_sel    (reg_sel),
    .imm_val    (imm_val)
  );

  // Checks on the combined outputs, next to the judge that produces them.
  always_comb begin
    AST_HITS_EXCLUSIVE: assert ($onehot0(ctx_hit)) else $error("two shapes matched"); // R8
    AST_IDLE_OUTPUTS: assert (one_hit || (reg_sel == '0 && imm_val == '0)) else $error("outputs not cleared"); // R8
    AST_EMPTY_NO_HIT: assert (!buf_empty || ctx_hit == '0) else $error("empty buffer matched"); // R1
    AST_NOP_TAIL_CLEAN: assert (!ctx_hit[imc_pkg::CTX_NOP] || instr_bits[BUF_W-1:8] == '0) else $error("no-op with dirty tail"); // R7
    AST_MOV_IMM_LE: assert (!ctx_hit[imc_pkg::CTX_MOVI] || imm_val == instr_bits[8 +: IMM_W]) else $error("move immediate order"); // R2
    AST_PUSH_REG: assert (!ctx_hit[imc_pkg::CTX_PUSH] || reg_sel == instr_bits[REG_W-1:0]) else $error("push register"); // R4
    AST_ADD_SEXT: assert (!ctx_hit[imc_pkg::CTX_ADDI] || imm_val[IMM_W-1:8] == {(IMM_W-8){imm_val[7]}}) else $error("add sign extension"); // R5
  end

endmodule

// File: tb/insn_encoding_checker_tb_top.sv
module insn_encoding_checker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 15;
  localparam int WATCHDOG   = 100000;

  logic          clk;
  logic          rst_n;
  logic [8*NB-1:0] instr_bits;
  logic [4:0]    ctx_hit;
  logic          one_hit;
  logic [2:0]    reg_sel;
  logic [31:0]   imm_val;

  int bb [NB];
  int n_vec;
  int n_bad;
  bit done;
  logic [31:0] lfsr;

  insn_encoding_checker dut_i (
    .instr_bits (instr_bits),
    .ctx_hit    (ctx_hit),
    .one_hit    (one_hit),
    .reg_sel    (reg_sel),
    .imm_val    (imm_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Independent reference from the requirement text.
  task automatic expect_of(output logic [4:0] e_hit, output logic e_one,
                           output logic [2:0] e_reg, output logic [31:0] e_imm);
    int lastnz;
    int n;
    longint acc;
    lastnz = -1;
    for (int k = 0; k < NB; k++) if (bb[k] != 0) lastnz = k;
    e_hit[0] = (bb[0] == 144) && (lastnz < 1);                          // R1
    e_hit[1] = (bb[0] / 8 == 23) && (lastnz < 5);                       // R2
    e_hit[2] = (bb[0] == 255) && (bb[1] / 8 == 24) && (lastnz < 2);     // R3
    e_hit[3] = (bb[0] / 8 == 10) && (lastnz < 1);                       // R4
    e_hit[4] = (bb[0] == 131) && (bb[1] / 8 == 24) && (lastnz < 3);     // R5
    n = 0;
    for (int c = 0; c < 5; c++) n += int'(e_hit[c]);
    e_one = (n == 1);
    e_reg = '0;
    e_imm = '0;
    if (e_one) begin
      if (e_hit[1] || e_hit[3]) e_reg = 3'(bb[0] % 8);
      if (e_hit[2] || e_hit[4]) e_reg = 3'(bb[1] % 8);
      if (e_hit[1]) begin
        acc = longint'(bb[1]) + 256 * longint'(bb[2]) + 65536 * longint'(bb[3])
            + 16777216 * longint'(bb[4]);
        e_imm = 32'(acc);
      end
      if (e_hit[4]) begin
        acc = (bb[2] < 128) ? longint'(bb[2]) : longint'(bb[2]) + 64'(32'hFFFFFF00);
        e_imm = 32'(acc);
      end
    end
  endtask

  task automatic clear_buf();
    for (int k = 0; k < NB; k++) bb[k] = 0;
  endtask

  task automatic load_shape(input int c, input int r, input int iv);
    clear_buf();
    case (c)
      0: bb[0] = 144;
      1: begin
        bb[0] = 184 + r;
        bb[1] = iv % 256; bb[2] = (iv / 256) % 256;
        bb[3] = (iv / 65536) % 256; bb[4] = (iv / 16777216) % 256;
      end
      2: begin bb[0] = 255; bb[1] = 192 + r; end
      3: bb[0] = 80 + r;
      default: begin bb[0] = 131; bb[1] = 192 + r; bb[2] = iv % 256; end
    endcase
  endtask

  task automatic run_vec(input string tag);
    logic [4:0]  e_hit;
    logic        e_one;
    logic [2:0]  e_reg;
    logic [31:0] e_imm;
    for (int k = 0; k < NB; k++) instr_bits[8*k +: 8] = 8'(bb[k]);
    expect_of(e_hit, e_one, e_reg, e_imm);
    @(posedge clk);
    #(CLK_PERIOD/4);
    n_vec++;
    if (ctx_hit !== e_hit || one_hit !== e_one || reg_sel !== e_reg || imm_val !== e_imm) begin
      n_bad++;
      $display("FAIL %s b0=%02h b1=%02h b2=%02h: actual hit=%b one=%b reg=%0d imm=%08h expected hit=%b one=%b reg=%0d imm=%08h",
               tag, bb[0], bb[1], bb[2], ctx_hit, one_hit, reg_sel, imm_val,
               e_hit, e_one, e_reg, e_imm);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    lfsr  = 32'h1234_5678;
    instr_bits = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: empty buffer gives no flag, one_hit low, zero outputs. R8
    clear_buf();
    run_vec("R8");

    // Every byte 0 value with a clean tail. R1/R2/R4
    for (int v = 0; v < 256; v++) begin
      clear_buf(); bb[0] = v;
      run_vec("R1/R2/R4");
    end

    // Increment shape: every ModRM byte. R3
    for (int v = 0; v < 256; v++) begin
      clear_buf(); bb[0] = 255; bb[1] = v;
      run_vec("R3");
    end

    // Add-immediate shape: every ModRM byte, several immediates. R5
    for (int v = 0; v < 256; v++) begin
      for (int j = 0; j < 4; j++) begin
        clear_buf(); bb[0] = 131; bb[1] = v;
        bb[2] = (j == 0) ? 0 : (j == 1) ? 127 : (j == 2) ? 128 : 255;
        run_vec("R5");
      end
    end

    // Register bits over all eight values in each register-bearing shape. R6
    for (int c = 0; c < 5; c++) begin
      for (int r = 0; r < 8; r++) begin
        load_shape(c, r, 32'h0000_A5C3);
        run_vec("R6");
      end
    end

    // Nonzero byte walked through every position behind every shape. R7
    for (int c = 0; c < 5; c++) begin
      for (int p = 0; p < NB; p++) begin
        for (int j = 0; j < 3; j++) begin
          load_shape(c, 5, 32'h4433_2211);
          bb[p] = (j == 0) ? 1 : (j == 1) ? 128 : 255;
          run_vec("R7");
        end
      end
    end

    // Mixed pseudo-random encodings, register numbers and immediates. R6
    for (int i = 0; i < 400; i++) begin
      lfsr = step(lfsr);
      load_shape(int'(lfsr % 5), int'((lfsr >> 3) % 8), int'(lfsr >> 1));
      if (((lfsr >> 8) % 4) == 0) bb[int'((lfsr >> 12) % 15)] = int'((lfsr >> 16) % 256);
      run_vec("R6");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still busy after %0d cycles, expected completion", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule